// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol front end of a byte-addressed serial memory that sits on a two-wire bus. It receives already synchronized clock and data line levels. It recognizes start and stop conditions and decodes the device address byte against a fixed four-bit type code and three board-level select pins. It then runs the write, set-address and read flows. The block pulls the data line low through an open-drain enable and never drives it high.

The memory side keeps the address counter, the array and the nonvolatile write timer. The engine tells it when to load a new 12-bit address, when to store a received data byte, when to fetch the next byte to send, and when a completed write transfer should be committed. A busy flag from the memory side makes the engine ignore its own address, so a host can poll for the end of a write cycle. The memory side returns `rd_data` one clock after `rd_req` and holds it there. SCL must stay high for at least four clock cycles so a fetched byte is in place before the first data bit goes out.

Top module: `twi_mem_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Until a start is seen, SCL pulses with data give no acknowledge, no SDA drive and no memory-side request.
- R2: The first byte after a start is taken MSB first. Bits 7..4 must equal 1010, bits 3..1 must equal `sel_pins[2:0]`, and bit 0 selects read (1) or write (0). On a match the engine pulls SDA low for the ninth clock. On a mismatch it leaves SDA released and waits for the next start.
- R3: While `mem_busy` is high, a matching address byte is not acknowledged. Once `mem_busy` is low, the same byte is acknowledged.
- R4: In a write, the two bytes after the address byte are acknowledged. After the second one, `addr_load` pulses for one cycle with `addr_val` = {first byte bits 3..0, second byte}.
- R5: Every later data byte in a write is acknowledged and produces a one-cycle `wr_req` pulse with that byte on `wr_data`.
- R6: A stop after at least one data byte pulses `commit_req` once. A stop anywhere else, including right after the two address bytes, pulses nothing, so a stop right after the two address bytes only loads the address.
- R7: A read address byte is acknowledged and pulses `rd_req`. The fetched byte is then driven MSB first, with SDA pulled low for 0 bits and released for 1 bits. SDA is released during the ninth clock.
- R8: If the master pulls SDA low on the ninth clock of a read byte, `rd_req` pulses and the next byte follows. If SDA is high on that clock, the engine stops driving and ignores clocks until the next start.
- R9: A repeated start after the two address bytes, followed by a read address byte, gives `addr_load` and then `rd_req`. The first byte sent comes from the loaded address.
- R10: `sda_pull` changes only in the cycle after an SCL falling edge, a start or a stop is detected, so SDA never changes while SCL is high during a byte.
- R11: At most one of `addr_load`, `wr_req`, `rd_req` and `commit_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus) |
| sel_pins | input | SEL_W | Board select pins compared with address bits 3..1 |
| mem_busy | input | 1 | Memory side is in a nonvolatile write cycle |
| rd_data | input | 8 | Byte returned one cycle after `rd_req` |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_load | output | 1 | Load `addr_val` into the memory-side counter |
| addr_val | output | ADDR_W | Address assembled from the two address bytes |
| wr_req | output | 1 | Store `wr_data` at the current counter |
| wr_data | output | 8 | Received data byte |
| rd_req | output | 1 | Fetch the byte at the current counter |
| commit_req | output | 1 | Start the nonvolatile write of the loaded bytes |

## Verification
The bench uses the default build: a 12-bit address, type code 1010, three select pins and the input register stage turned on. Under these settings the full high-nibble and low-byte address assembly is exercised. The one-cycle fetch latency is checked against a four-cycle SCL high phase, and both select-pin mismatch and match can be reached by changing the pins between transfers. A behavioural memory with a busy timer lets acknowledge polling, the set-address flow and reading back written bytes be seen at the ports.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT
   } twi_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon #(
   parameter bit IN_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, sda_s;
   logic scl_q, sda_q;

   generate
      if (IN_REG) begin : g_inreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_s <= 1'b1;
               sda_s <= 1'b1;
            end else begin
               scl_s <= scl_i;
               sda_s <= sda_i;
            end
         end
      end else begin : g_direct
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !start_det); // R1
endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift #(
   parameter int unsigned BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic rise,
   input  logic sda,
   output logic [$clog2(BITS+1)-1:0] bit_idx,
   output logic byte_done,
   output logic ack_slot,
   output logic [BITS-1:0] rx_byte
);
   localparam int unsigned CW = $clog2(BITS + 1);
   localparam logic [CW-1:0] LAST = CW'(BITS - 1);
   localparam logic [CW-1:0] SLOT = CW'(BITS);

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("twi_byte_shift: BITS must be at least 2");
      end
   endgenerate

   logic [BITS-1:0] sh_q;
   logic [CW-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (rise) begin
         if (cnt_q == SLOT) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[BITS-2:0], sda};
         end
      end
   end

   assign bit_idx   = cnt_q;
   assign byte_done = rise && (cnt_q == LAST);
   assign ack_slot  = rise && (cnt_q == SLOT);
   assign rx_byte   = {sh_q[BITS-2:0], sda};

   AST_DONE_THEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (bit_idx == SLOT)); // R2
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
   import twi_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned TYPE_W    = 4,
   parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_det,
   input  logic stop_det,
   input  logic scl_fall,
   input  logic byte_done,
   input  logic ack_slot,
   input  logic [3:0] bit_idx,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic sda_lvl,
   input  logic [SEL_W-1:0] sel_pins,
   input  logic mem_busy,
   input  logic [BYTE_W-1:0] rd_data,
   output logic sda_pull,
   output logic addr_load,
   output logic [ADDR_W-1:0] addr_val,
   output logic wr_req,
   output logic [BYTE_W-1:0] wr_data,
   output logic rd_req,
   output logic commit_req
);
   localparam int unsigned HI_W = ADDR_W - BYTE_W;
   localparam logic [3:0]  SLOT = 4'(BYTE_W);

   generate
      if (TYPE_W + SEL_W + 1 != BYTE_W) begin : g_bad_dev
         $error("twi_ctrl: type, select and R/W bits must fill one byte");
      end
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("twi_ctrl: ADDR_W must lie in 9..16");
      end
   endgenerate

   twi_state_t        state_q;
   logic              ack_pend_q;
   logic              wrote_q;
   logic              load_tx_q;
   logic [HI_W-1:0]   hi_q;
   logic [BYTE_W-1:0] tx_q;
   logic              dev_match;

   assign dev_match = (rx_byte[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                      (rx_byte[SEL_W:1] == sel_pins);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ack_pend_q <= 1'b0;
         wrote_q    <= 1'b0;
         load_tx_q  <= 1'b0;
         hi_q       <= '0;
         tx_q       <= '1;
         sda_pull   <= 1'b0;
         addr_load  <= 1'b0;
         addr_val   <= '0;
         wr_req     <= 1'b0;
         wr_data    <= '0;
         rd_req     <= 1'b0;
         commit_req <= 1'b0;
      end else begin
         addr_load  <= 1'b0;
         wr_req     <= 1'b0;
         rd_req     <= 1'b0;
         commit_req <= 1'b0;
         load_tx_q  <= rd_req;
         if (load_tx_q) begin
            tx_q <= rd_data;
         end

         if (start_det) begin
            state_q    <= ST_DEV;
            ack_pend_q <= 1'b0;
            wrote_q    <= 1'b0;
            sda_pull   <= 1'b0;
         end else if (stop_det) begin
            if (state_q == ST_WDAT && wrote_q) begin
               commit_req <= 1'b1;
            end
            state_q    <= ST_IDLE;
            ack_pend_q <= 1'b0;
            wrote_q    <= 1'b0;
            sda_pull   <= 1'b0;
         end else begin
            if (byte_done) begin
               unique case (state_q)
                  ST_DEV: begin
                     if (dev_match && !mem_busy) begin
                        ack_pend_q <= 1'b1;
                        if (rx_byte[0]) begin
                           state_q <= ST_RDAT;
                           rd_req  <= 1'b1;
                        end else begin
                           state_q <= ST_AHI;
                        end
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
                  ST_AHI: begin
                     hi_q       <= rx_byte[HI_W-1:0];
                     ack_pend_q <= 1'b1;
                     state_q    <= ST_ALO;
                  end
                  ST_ALO: begin
                     addr_load  <= 1'b1;
                     addr_val   <= {hi_q, rx_byte};
                     ack_pend_q <= 1'b1;
                     state_q    <= ST_WDAT;
                  end
                  ST_WDAT: begin
                     wr_req     <= 1'b1;
                     wr_data    <= rx_byte;
                     wrote_q    <= 1'b1;
                     ack_pend_q <= 1'b1;
                  end
                  default: begin
                  end
               endcase
            end

            if (ack_slot) begin
               ack_pend_q <= 1'b0;
               if (state_q == ST_RDAT && !ack_pend_q) begin
                  if (!sda_lvl) begin
                     rd_req <= 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end

            if (scl_fall) begin
               if (bit_idx == SLOT) begin
                  sda_pull <= ack_pend_q;
               end else if (state_q == ST_RDAT) begin
                  sda_pull <= ~tx_q[3'd7 - bit_idx[2:0]];
               end else begin
                  sda_pull <= 1'b0;
               end
            end
         end
      end
   end

   AST_PULL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det)); // R10
   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && state_q == ST_DEV && mem_busy) |=> !ack_pend_q); // R3
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_load, wr_req, rd_req, commit_req})); // R11
   AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> $past(stop_det)); // R6
   AST_LOAD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |-> (ack_pend_q && state_q == ST_WDAT)); // R4
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned SEL_W     = 3,
   parameter logic [3:0]  TYPE_CODE = 4'b1010,
   parameter bit          IN_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  sel_pins,
   input  logic              mem_busy,
   input  logic [7:0]        rd_data,
   output logic              sda_pull,
   output logic              addr_load,
   output logic [ADDR_W-1:0] addr_val,
   output logic              wr_req,
   output logic [7:0]        wr_data,
   output logic              rd_req,
   output logic              commit_req
);
   localparam int unsigned BITS = twi_pkg::BYTE_W;

   logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic [3:0] bit_idx;
   logic       byte_done, ack_slot;
   logic [7:0] rx_byte;

   twi_line_mon #(.IN_REG(IN_REG)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_byte_shift #(.BITS(BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(start_det | stop_det),
      .rise(scl_rise), .sda(sda_lvl), .bit_idx(bit_idx),
      .byte_done(byte_done), .ack_slot(ack_slot), .rx_byte(rx_byte)
   );

   twi_ctrl #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .TYPE_W(4), .TYPE_CODE(TYPE_CODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
      .scl_fall(scl_fall), .byte_done(byte_done), .ack_slot(ack_slot),
      .bit_idx(bit_idx), .rx_byte(rx_byte), .sda_lvl(sda_lvl),
      .sel_pins(sel_pins), .mem_busy(mem_busy), .rd_data(rd_data),
      .sda_pull(sda_pull), .addr_load(addr_load), .addr_val(addr_val),
      .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
      .commit_req(commit_req)
   );
endmodule

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;
   localparam int AW = 12;
   localparam int BUSY_CYC = 300;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic [2:0] sel = 3'b010;
   logic mem_busy;
   logic [7:0] rd_data = 8'h00;
   logic sda_pull, addr_load, wr_req, rd_req, commit_req;
   logic [AW-1:0] addr_val;
   logic [7:0] wr_data;
   logic sda_line;

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_pull;

   twi_mem_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sel_pins(sel), .mem_busy(mem_busy), .rd_data(rd_data),
      .sda_pull(sda_pull), .addr_load(addr_load), .addr_val(addr_val),
      .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
      .commit_req(commit_req)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit chk_en = 1'b0;
   bit exp_pull = 1'b0;
   string cur_req = "R1";
   int exp_kind[$];
   int exp_val[$];

   // behavioural memory side
   logic [7:0] mem [0:(1<<AW)-1];
   int ptr = 0;
   int busy_cnt = 0;
   assign mem_busy = (busy_cnt != 0);

   function automatic logic [7:0] pat(int a);
      return 8'((a * 7 + 3) ^ (a >> 5));
   endfunction

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = pat(i);
   end

   always @(posedge clk) begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (addr_load) ptr <= int'(addr_val);
      if (wr_req) begin
         mem[ptr] <= wr_data;
         ptr <= (ptr & ~31) | ((ptr + 1) & 31);
      end
      if (rd_req) begin
         rd_data <= mem[ptr];
         ptr <= (ptr + 1) % (1 << AW);
      end
      if (commit_req) busy_cnt <= BUSY_CYC;
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog %s: actual running, expected done", cur_req);
         report();
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock comparison of the open-drain enable against the model
   always @(negedge clk) begin
      if (rst_n && chk_en) chk(sda_pull === exp_pull, cur_req, sda_pull, exp_pull);
   end

   // per-clock comparison of memory-side pulses against the expected queue
   task automatic take_evt(int kind, int val);
      if (exp_kind.size() == 0) begin
         chk(1'b0, {cur_req, " R11 unexpected pulse"}, kind, 0);
      end else begin
         chk(exp_kind[0] == kind && exp_val[0] == val, cur_req,
             kind * 4096 + val, exp_kind[0] * 4096 + exp_val[0]);
         void'(exp_kind.pop_front());
         void'(exp_val.pop_front());
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(($countones({addr_load, wr_req, rd_req, commit_req}) <= 1),
             "R11", {addr_load, wr_req, rd_req, commit_req}, 0);
         if (addr_load)  take_evt(1, int'(addr_val));
         if (wr_req)     take_evt(2, int'(wr_data));
         if (rd_req)     take_evt(3, 0);
         if (commit_req) take_evt(4, 0);
      end
   end

   task automatic expect_evt(int kind, int val);
      exp_kind.push_back(kind);
      exp_val.push_back(val);
   endtask

   task automatic drain(string req);
      chk(exp_kind.size() == 0, req, exp_kind.size(), 0);
      exp_kind.delete();
      exp_val.delete();
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic clk_bit(bit b, bit ep);
      sda_m = b;
      tick(4);
      scl = 1'b1;
      exp_pull = ep;
      chk_en = 1'b1;
      tick(4);
      chk_en = 1'b0;
      scl = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      tick(2);
      scl = 1'b1;
      tick(4);
      sda_m = 1'b0;
      tick(4);
      scl = 1'b0;
      tick(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      tick(2);
      scl = 1'b1;
      tick(4);
      sda_m = 1'b1;
      tick(4);
   endtask

   task automatic send_byte(logic [7:0] b, bit ack_exp);
      for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0);
      clk_bit(1'b1, ack_exp);
   endtask

   task automatic recv_byte(logic [7:0] e, bit mack);
      for (int i = 7; i >= 0; i--) clk_bit(1'b1, ~e[i]);
      clk_bit(~mack, 1'b0);
   endtask

   initial begin
      tick(3);
      chk(sda_pull === 1'b0, "R1 reset pull", sda_pull, 0);
      chk({addr_load, wr_req, rd_req, commit_req} === 4'b0, "R11 reset pulses",
          {addr_load, wr_req, rd_req, commit_req}, 0);
      rst_n = 1'b1;
      tick(4);

      // R1: clocked bytes without a start are ignored
      cur_req = "R1";
      scl = 1'b0;
      send_byte(8'b1010_0100, 1'b0);
      send_byte(8'b1010_0101, 1'b0);
      drain("R1");
      bus_stop();

      // R2: wrong type code, then wrong select bits
      cur_req = "R2";
      bus_start();
      send_byte(8'b1011_0100, 1'b0);
      send_byte(8'h00, 1'b0);
      bus_stop();
      bus_start();
      send_byte(8'b1010_1100, 1'b0);
      bus_stop();
      drain("R2");

      // R4/R5/R6: write three bytes at 0xA3E with select pins 101
      sel = 3'b101;
      cur_req = "R4";
      expect_evt(1, 12'hA3E);
      bus_start();
      send_byte(8'b1010_1010, 1'b1);
      send_byte(8'h0A, 1'b1);
      send_byte(8'h3E, 1'b1);
      cur_req = "R5";
      expect_evt(2, 8'h11);
      expect_evt(2, 8'h22);
      expect_evt(2, 8'h33);
      send_byte(8'h11, 1'b1);
      send_byte(8'h22, 1'b1);
      send_byte(8'h33, 1'b1);
      cur_req = "R6";
      expect_evt(4, 0);
      bus_stop();
      tick(2);
      drain("R6 commit");
      chk(mem_busy === 1'b1, "R3 busy started", mem_busy, 1);

      // R3: polling while busy gets no acknowledge
      cur_req = "R3";
      bus_start();
      send_byte(8'b1010_1010, 1'b0);
      bus_stop();
      tick(BUSY_CYC + 20);
      chk(mem_busy === 1'b0, "R3 busy ended", mem_busy, 0);
      bus_start();
      send_byte(8'b1010_1010, 1'b1);
      bus_stop();
      drain("R3");

      // R6: set current address only
      cur_req = "R6";
      expect_evt(1, 12'hA3F);
      bus_start();
      send_byte(8'b1010_1010, 1'b1);
      send_byte(8'h0A, 1'b1);
      send_byte(8'h3F, 1'b1);
      bus_stop();
      tick(4);
      drain("R6 set address");
      chk(mem_busy === 1'b0, "R6 no commit", mem_busy, 0);

      // R7/R8: current address read, two bytes, then NACK
      cur_req = "R7";
      expect_evt(3, 0);
      expect_evt(3, 0);
      bus_start();
      send_byte(8'b1010_1011, 1'b1);
      recv_byte(8'h22, 1'b1);
      cur_req = "R8";
      recv_byte(pat(12'hA40), 1'b0);
      send_byte(8'h00, 1'b0);
      bus_stop();
      drain("R8");

      // R9: random read at 0xA3E
      cur_req = "R9";
      expect_evt(1, 12'hA3E);
      expect_evt(3, 0);
      bus_start();
      send_byte(8'b1010_1010, 1'b1);
      send_byte(8'h0A, 1'b1);
      send_byte(8'h3E, 1'b1);
      bus_start();
      send_byte(8'b1010_1011, 1'b1);
      recv_byte(8'h11, 1'b0);
      bus_stop();
      drain("R9");

      // R6: stop after one address byte loads nothing; read continues at 0xA3F
      cur_req = "R6";
      bus_start();
      send_byte(8'b1010_1010, 1'b1);
      send_byte(8'h01, 1'b1);
      bus_stop();
      drain("R6 partial address");
      cur_req = "R10";
      expect_evt(3, 0);
      bus_start();
      send_byte(8'b1010_1011, 1'b1);
      recv_byte(8'h22, 1'b0);
      bus_stop();
      drain("R10");

      tick(10);
      report();
   end
endmodule